// File: doc/BRIEF.md
# Interrupt source priority controller

This block is the source stage of a two-level interrupt scheme. It receives a set of level-sensitive interrupt wires, lets software give each wire an 8-bit priority through a 32-bit register slave, and continuously offers the single most favoured pending, unmasked source to a downstream presentation controller. The downstream side sees a valid flag, the global interrupt number of the offered source (a fixed base plus the source index) and that source's priority.

Software first reads the configuration word to learn the number base and how many priority bits are implemented, then writes a priority into each per-source word. A priority of 0xFF masks the source; lower values are more favoured. The per-source word also shows the live level of its wire, so software can poll a source without going through the presentation path. A diagnostic word shows all input levels at once.

Top module: `irq_src_ctrl`

## Requirements
- R1: The word at offset 0x000 reads the source-number base (16) in bits 23..0 and the implemented priority-bit count PRIO_BITS (1 to 8) in bits 27..24, with all other bits zero; writes to it have no effect.
- R2: The word at offset 0x004 reads the live input levels, bit k showing source k and unused bits zero; writes to it have no effect.
- R3: The per-source word of source k at offset 0x800 + 4k reads the live input level in bit 31 and again in bit 29 (pending), the priority in bits 7..0, and zero in bit 30, bit 28 and bits 27..8.
- R4: A write to a per-source word stores only bits 7..0, keeping the upper PRIO_BITS bits of the written byte and forcing the remaining low bits to one; the other written bits are ignored.
- R5: After reset every priority reads 0xFF and the valid output is low.
- R6: A source qualifies when its input is high and its priority is not 0xFF; the offered source is the qualifying one with the numerically lowest priority, ties going to the lowest index; with no qualifying source the valid output is low.
- R7: The number output is 16 plus the offered source index and the priority output is that source's priority; both, with the valid output, are registered and reflect inputs and priorities as they stood at the previous clock edge.
- R8: Reads of any other offset, including per-source words beyond the last source, return zero, and writes there change no priority.
- R9: Every cycle with the request high is answered by the acknowledge high in the next cycle, with read data valid in that same cycle; the acknowledge is low after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after the request |
| irq_in | input | NUM_SRC | Level-sensitive interrupt inputs |
| pres_valid | output | 1 | A qualifying source is offered |
| pres_num | output | 24 | Global number of the offered source |
| pres_prio | output | 8 | Priority of the offered source |

## Verification
Register results are due one cycle after the request: the bench raises the request on a falling edge and samples acknowledge and read data on the next falling edge, then checks on the following falling edge that the acknowledge has dropped. Presentation results are due one edge after their cause, so after each priority write or input change the bench first confirms at the falling edge before the next rising edge that the outputs still show the old choice, then checks the new choice one falling edge later. Expected priorities and winners come from an arithmetic model in the bench swept over all byte values and hundreds of pseudo-random priority and input patterns.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;

  // Arbitration candidate travelling along the selection chain.
  typedef struct packed {
    logic       valid;
    logic [7:0] prio;
    logic [7:0] idx;
  } cand_t;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  // Keep the implemented upper bits of a priority, force the rest to one.
  function automatic logic [7:0] prio_trim(input logic [7:0] v, input int bits);
    return v | (8'hFF >> bits);
  endfunction

  // Read image of one per-source word.
  function automatic logic [31:0] src_word(input logic level, input logic [7:0] prio);
    return {level, 1'b0, level, 1'b0, 20'd0, prio};
  endfunction

  // Read image of the configuration word.
  function automatic logic [31:0] cfg_word(input int base, input int bits);
    return {4'd0, 4'(bits), 24'(base)};
  endfunction

  // Global number of a source.
  function automatic logic [23:0] src_number(input int base, input logic [7:0] idx);
    return 24'(base) + {16'd0, idx};
  endfunction

endpackage

// File: rtl/irqsc_regs.sv
module irqsc_regs
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 4,
  parameter int IRQ_BASE  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ack,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic [NUM_SRC*8-1:0] prio_flat,
  output logic                 wr_prio_hit,
  output logic                 rd_unmapped
);

  localparam int IDXW = 9;

  logic [IDXW-1:0] acc_idx;
  logic            hit_cfg;
  logic            hit_dbg;
  logic            hit_src;
  logic [31:0]     dbg_word;
  logic [31:0]     rd_next;
  logic [7:0]      prio_q [NUM_SRC];

  assign acc_idx = bus_addr[10:2];
  assign hit_cfg = (bus_addr[11:2] == 10'd0);
  assign hit_dbg = (bus_addr[11:2] == 10'd1);
  assign hit_src = bus_addr[11] && (acc_idx < IDXW'(NUM_SRC));

  assign wr_prio_hit = bus_req && bus_we && hit_src;
  assign rd_unmapped = bus_req && !bus_we && !hit_cfg && !hit_dbg && !hit_src;

  always_comb begin
    dbg_word = '0;
    dbg_word[NUM_SRC-1:0] = irq_in;
  end

  // Per-source priority storage.
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[k] <= PRIO_MASKED;
      end else if (wr_prio_hit && (acc_idx == IDXW'(k))) begin
        prio_q[k] <= prio_trim(bus_wdata[7:0], PRIO_BITS);
      end
    end
    assign prio_flat[k*8 +: 8] = prio_q[k];
  end

  // Read multiplexer.
  always_comb begin
    rd_next = '0;
    if (hit_cfg) begin
      rd_next = cfg_word(IRQ_BASE, PRIO_BITS);
    end else if (hit_dbg) begin
      rd_next = dbg_word;
    end else if (hit_src) begin
      for (int k = 0; k < NUM_SRC; k++) begin
        if (acc_idx == IDXW'(k)) rd_next = src_word(irq_in[k], prio_q[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_next : '0;
    end
  end

endmodule

// File: rtl/irqsc_arbiter.sv
module irqsc_arbiter
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic                 sel_valid,
  output logic [7:0]           sel_idx,
  output logic [7:0]           sel_prio
);

  cand_t [NUM_SRC:0] chain;

  assign chain[0] = '0;

  // Walk sources from index 0 upward; a later source only wins when
  // strictly more favoured, so ties stay with the lower index.
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_stage
    logic [7:0] p;
    logic       elig;
    logic       take;
    assign p    = prio_flat[k*8 +: 8];
    assign elig = pend[k] && (p != PRIO_MASKED);
    assign take = elig && (!chain[k].valid || (p < chain[k].prio));
    assign chain[k+1] = take ? cand_t'{valid: 1'b1, prio: p, idx: 8'(k)} : chain[k];
  end

  assign sel_valid = chain[NUM_SRC].valid;
  assign sel_idx   = chain[NUM_SRC].idx;
  assign sel_prio  = chain[NUM_SRC].prio;

endmodule

// File: rtl/irqsc_present.sv
module irqsc_present
  import irqsc_pkg::*;
#(
  parameter int IRQ_BASE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_valid,
  input  logic [7:0]  sel_idx,
  input  logic [7:0]  sel_prio,
  output logic        pres_valid,
  output logic [23:0] pres_num,
  output logic [7:0]  pres_prio
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_valid <= 1'b0;
      pres_num   <= '0;
      pres_prio  <= PRIO_MASKED;
    end else begin
      pres_valid <= sel_valid;
      pres_num   <= sel_valid ? src_number(IRQ_BASE, sel_idx) : '0;
      pres_prio  <= sel_valid ? sel_prio : PRIO_MASKED;
    end
  end

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irqsc_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 4,
  parameter int IRQ_BASE  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ack,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               pres_valid,
  output logic [23:0]        pres_num,
  output logic [7:0]         pres_prio
);

  logic [NUM_SRC*8-1:0] prio_flat;
  logic                 wr_prio_hit;
  logic                 rd_unmapped;
  logic                 sel_valid;
  logic [7:0]           sel_idx;
  logic [7:0]           sel_prio;

  irqsc_regs #(
    .NUM_SRC  (NUM_SRC),
    .PRIO_BITS(PRIO_BITS),
    .IRQ_BASE (IRQ_BASE)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack),
    .irq_in     (irq_in),
    .prio_flat  (prio_flat),
    .wr_prio_hit(wr_prio_hit),
    .rd_unmapped(rd_unmapped)
  );

  irqsc_arbiter #(
    .NUM_SRC(NUM_SRC)
  ) arb_i (
    .pend     (irq_in),
    .prio_flat(prio_flat),
    .sel_valid(sel_valid),
    .sel_idx  (sel_idx),
    .sel_prio (sel_prio)
  );

  irqsc_present #(
    .IRQ_BASE(IRQ_BASE)
  ) pres_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_prio  (sel_prio),
    .pres_valid(pres_valid),
    .pres_num  (pres_num),
    .pres_prio (pres_prio)
  );

endmodule

// File: rtl/irqsc_chk.sv
module irqsc_chk #(
  parameter int NUM_SRC  = 8,
  parameter int IRQ_BASE = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_ack,
  input logic [31:0]        bus_rdata,
  input logic               rd_unmapped,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               sel_valid,
  input logic [7:0]         sel_idx,
  input logic [7:0]         sel_prio,
  input logic               pres_valid,
  input logic [23:0]        pres_num,
  input logic [7:0]         pres_prio
);

  p_ack_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);

  p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (bus_rdata == 32'd0));

  p_sel_qualifies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((|(irq_in & (NUM_SRC'(1) << sel_idx))) && (sel_prio != 8'hFF)));

  p_pres_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> (pres_valid && (pres_num == 24'(IRQ_BASE) + 24'($past(sel_idx)))
                   && (pres_prio == $past(sel_prio))));

  p_pres_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> !pres_valid);

endmodule

bind irq_src_ctrl irqsc_chk #(
  .NUM_SRC (NUM_SRC),
  .IRQ_BASE(IRQ_BASE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .bus_rdata  (bus_rdata),
  .rd_unmapped(rd_unmapped),
  .irq_in     (irq_in),
  .sel_valid  (sel_valid),
  .sel_idx    (sel_idx),
  .sel_prio   (sel_prio),
  .pres_valid (pres_valid),
  .pres_num   (pres_num),
  .pres_prio  (pres_prio)
);

// File: tb/irq_src_ctrl_tb_top.sv
module irq_src_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 8;
  localparam int PBITS      = 4;
  localparam int BASE       = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_ack;
  logic [NSRC-1:0] irq_in = '0;
  logic            pres_valid;
  logic [23:0]     pres_num;
  logic [7:0]      pres_prio;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_prio [NSRC];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_ctrl #(.NUM_SRC(NSRC), .PRIO_BITS(PBITS), .IRQ_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq_in(irq_in), .pres_valid(pres_valid),
    .pres_num(pres_num), .pres_prio(pres_prio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Expected stored priority: upper PBITS of v kept, low bits set.
  function automatic logic [7:0] exp_prio(input logic [7:0] v);
    int lo = 8 - PBITS;
    return 8'(((int'(v) >> lo) << lo) | ((1 << lo) - 1));
  endfunction

  // Expected winner: scan downward, lower-or-equal takes over.
  task automatic exp_winner(output logic v, output int idx, output logic [7:0] p);
    v = 1'b0; idx = 0; p = 8'hFF;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (irq_in[k] && m_prio[k] != 8'hFF && (!v || m_prio[k] <= p)) begin
        v = 1'b1; idx = k; p = m_prio[k];
      end
    end
  endtask

  // One access; returns at the falling edge where ack/rdata are due.
  task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check("R9 ack", {31'd0, bus_ack}, 32'd1);
    rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] unused;
    access(1'b1, a, d, unused);
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] got;
    access(1'b0, a, '0, got);
    check(req, got, exp);
  endtask

  task automatic check_pres(input string req);
    logic v; int idx; logic [7:0] p;
    exp_winner(v, idx, p);
    check({req, " valid"}, {31'd0, pres_valid}, {31'd0, v});
    if (v) begin
      check({req, " num"}, {8'd0, pres_num}, 32'(BASE + idx));
      check({req, " prio"}, {24'd0, pres_prio}, {24'd0, p});
    end
  endtask

  initial begin
    logic [31:0] w;
    for (int k = 0; k < NSRC; k++) m_prio[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state
    check("R5 valid after reset", {31'd0, pres_valid}, 32'd0);
    for (int k = 0; k < NSRC; k++) rd_check("R5 reset prio", 12'h800 + 12'(4*k), 32'h0000_00FF);
    @(negedge clk);
    check("R9 ack drops", {31'd0, bus_ack}, 32'd0);

    // R1: configuration word, writes ignored
    rd_check("R1 config", 12'h000, {4'd0, 4'(PBITS), 24'(BASE)});
    wr(12'h000, 32'hFFFF_FFFF);
    rd_check("R1 config after write", 12'h000, {4'd0, 4'(PBITS), 24'(BASE)});

    // R2: diagnostic word
    irq_in = 8'hA5;
    rd_check("R2 levels", 12'h004, 32'h0000_00A5);
    wr(12'h004, 32'h0000_0000);
    irq_in = 8'h3C;
    rd_check("R2 levels after write", 12'h004, 32'h0000_003C);

    // R3: per-source words show live level in bits 31 and 29
    irq_in = 8'hA5;
    for (int k = 0; k < NSRC; k++)
      rd_check("R3 source word", 12'h800 + 12'(4*k),
               (irq_in[k] ? 32'hA000_0000 : 32'h0) | 32'h0000_00FF);
    @(negedge clk);
    check("R5 all masked no valid", {31'd0, pres_valid}, 32'd0);

    // R8: unmapped reads and writes
    rd_check("R8 unmapped 0x008", 12'h008, 32'd0);
    rd_check("R8 unmapped 0x7FC", 12'h7FC, 32'd0);
    rd_check("R8 beyond last source", 12'h800 + 12'(4*NSRC), 32'd0);
    wr(12'h800 + 12'(4*NSRC), 32'h0000_0000);
    wr(12'h400, 32'h0000_0000);
    for (int k = 0; k < NSRC; k++)
      rd_check("R8 no side effect", 12'h800 + 12'(4*k),
               (irq_in[k] ? 32'hA000_0000 : 32'h0) | 32'h0000_00FF);

    // R4: sweep every byte value, upper written bits ignored
    irq_in = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(12'h80C, 32'hFFFF_FF00 | 32'(v));
      rd_check("R4 trimmed prio", 12'h80C, {24'd0, exp_prio(8'(v))});
    end
    wr(12'h80C, 32'h0000_00FF);

    // R6: tie goes to lower index
    wr(12'h808, 32'h0000_0050); m_prio[2] = exp_prio(8'h50);
    wr(12'h814, 32'h0000_0050); m_prio[5] = exp_prio(8'h50);
    @(negedge clk);
    irq_in = 8'b0010_0100;
    check("R7 old output held", {31'd0, pres_valid}, 32'd0);
    @(negedge clk);
    check_pres("R6 tie lowest index");
    // Masked favoured source loses
    wr(12'h814, 32'h0000_0010); m_prio[5] = exp_prio(8'h10);
    check("R7 before update", {8'd0, pres_num}, 32'(BASE + 2));
    @(negedge clk);
    check_pres("R6 lower prio wins");
    wr(12'h814, 32'h0000_00FF); m_prio[5] = 8'hFF;
    @(negedge clk);
    check_pres("R6 masked source skipped");
    irq_in = 8'h00;
    @(negedge clk);
    check_pres("R6 none pending");

    // R6/R7: pseudo-random sweep
    for (int it = 0; it < 300; it++) begin
      for (int k = 0; k < NSRC; k++) begin
        w = rnd();
        w[7:0] = (w[9:8] == 2'd0) ? 8'hFF : {w[7:6], 6'd0};
        wr(12'h800 + 12'(4*k), w);
        m_prio[k] = exp_prio(w[7:0]);
      end
      @(negedge clk);
      check_pres("R7 settled after writes");
      w = rnd();
      irq_in = w[NSRC-1:0];
      @(negedge clk);
      check_pres("R6 R7 random pattern");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule